// File: doc/BRIEF.md
# PCI Host Bridge Configuration Register File

This block holds the function-0 configuration bytes of a PCI host bridge. A byte-wide access port carries a function number, an 8-bit offset, a write strobe and write data. Reads return combinationally. Each write passes a per-offset filter before it is stored. Identity and header bytes cannot be changed. Some command and status bytes are masked or forced. Everything else is stored as written.

Seven bytes, at offsets 0x59 to 0x5F, hold 2-bit read/write attributes for the upper memory regions. They are exported as a flat bus, together with a BIOS-shadow flag. Whenever a write changes one attribute nibble, the block gives a one-cycle notification that carries the region index and the new attribute. Downstream address-routing logic can then rebuild only that region. A master-reset input returns the BIOS region to its cleared state. A variant input selects one of two sets of reset defaults.

Top module: `hb_cfg_space`

## Requirements
- R1: When `acc_fn` is nonzero, `acc_rdata` is 0xFF, and a write has no effect on any stored byte or on the notify outputs.
- R2: Writes have no effect at offsets 0x00–0x03, 0x08–0x0C, 0x0E and 0x10–0x4E.
- R3: A write to offset 0x04 stores `(data & 0x42) | 0x04`. A write to offset 0x05 stores `data & 0x01`.
- R4: A write to offset 0x06 stores 0x00. A write to offset 0x07 stores 0x02.
- R5: Reset loads these values: 0x00=0x86, 0x01=0x80, 0x02=0xA3, 0x03=0x04, 0x04=0x06, 0x07=0x02, 0x0B=0x06, 0x57=0x31, and 0x02 at 0x60–0x64. Bytes not named here or in R6 reset to 0x00. A write to any offset not covered by R2–R4 stores the data unchanged.
- R6: The defaults depend on `variant_sel` during reset. With 0: 0x08=0x03, 0x50=0x80, 0x52=0x40. With 1: 0x08=0x10, 0x50=0xA0, 0x52=0x44, 0x66=0x02, 0x67=0x02.
- R7: A write to 0x59 that changes bits 7:4 gives a notification for region 0, with attribute = new bits 5:4. A change in bits 3:0 only gives no notification. `shadow_on` equals bit 4 of byte 0x59.
- R8: For offset 0x59+k (k = 1..6), a changed low nibble notifies region 2k−1 with attribute = new bits 1:0. A changed high nibble notifies region 2k with attribute = new bits 5:4. A nibble that does not change gives no notification.
- R9: A pulse on `master_rst` acts as a write of 0x00 to 0x59, including its notification. An access-port write in the same cycle is discarded.
- R10: A notification appears on the cycle after the write, with `upd_valid` high for one cycle. When one write changes both nibbles, the low-nibble region is notified first and the high-nibble region on the next cycle.
- R11: While `strap_mute5b` is high, writes to 0x5B are stored but give no notification.
- R12: `attr_bytes[8k+7:8k]` equals the stored byte at offset 0x59+k, for k = 0..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_sel | input | 1 | Selects the reset-default set |
| strap_mute5b | input | 1 | Suppresses notifications for offset 0x5B |
| master_rst | input | 1 | Clears byte 0x59 as if written with 0x00 |
| acc_fn | input | 3 | Function number of the access |
| acc_off | input | 8 | Register offset |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| attr_bytes | output | 56 | Attribute bytes 0x59–0x5F, byte k at bits 8k+7:8k |
| shadow_on | output | 1 | BIOS shadow flag |
| upd_valid | output | 1 | One-cycle notification strobe |
| upd_region | output | 4 | Region index 0–12 |
| upd_attr | output | 2 | New 2-bit attribute of that region |

## Verification
The ordering and strap properties assume one input rule: after a write that changes both nibbles of an attribute byte, the next cycle carries neither an attribute write nor a master reset. Without that gap the pending high-nibble notification would collide with a new one. The bench's write task always leaves two idle cycles after each strobe, so every notification slot is observed in isolation. It also drives `master_rst` only from that idle state.

// File: rtl/hb_cfg_space.sv
module hb_cfg_space #(
  parameter int FN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            variant_sel,
  input  logic            strap_mute5b,
  input  logic            master_rst,
  input  logic [FN_W-1:0] acc_fn,
  input  logic [7:0]      acc_off,
  input  logic            acc_we,
  input  logic [7:0]      acc_wdata,
  output logic [7:0]      acc_rdata,
  output logic [55:0]     attr_bytes,
  output logic            shadow_on,
  output logic            upd_valid,
  output logic [3:0]      upd_region,
  output logic [1:0]      upd_attr
);
  localparam int NREG = 256;
  localparam int N_ATTR = 7;
  localparam logic [7:0] ATTR_BASE = 8'h59;
  localparam logic [7:0] ATTR_LAST = ATTR_BASE + 8'(N_ATTR - 1);
  localparam logic [7:0] MUTE_OFF = ATTR_BASE + 8'd2;

  logic [7:0] cfg [NREG];

  function automatic logic [7:0] dflt(input logic [7:0] o, input logic v);
    case (o)
      8'h00: return 8'h86;
      8'h01: return 8'h80;
      8'h02: return 8'hA3;
      8'h03: return 8'h04;
      8'h04: return 8'h06;
      8'h07: return 8'h02;
      8'h08: return v ? 8'h10 : 8'h03;
      8'h0B: return 8'h06;
      8'h50: return v ? 8'hA0 : 8'h80;
      8'h52: return v ? 8'h44 : 8'h40;
      8'h57: return 8'h31;
      8'h60, 8'h61, 8'h62, 8'h63, 8'h64: return 8'h02;
      8'h66, 8'h67: return v ? 8'h02 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic locked(input logic [7:0] o);
    return (o >= 8'h10 && o <= 8'h4E) || (o <= 8'h03) ||
           (o >= 8'h08 && o <= 8'h0C) || (o == 8'h0E);
  endfunction

  function automatic logic [7:0] filt(input logic [7:0] o, input logic [7:0] d);
    case (o)
      8'h04: return (d & 8'h42) | 8'h04;
      8'h05: return d & 8'h01;
      8'h06: return 8'h00;
      8'h07: return 8'h02;
      default: return d;
    endcase
  endfunction

  logic       wr_go, w_en, in_attr, mute, ev_lo, ev_hi;
  logic [7:0] w_off, w_val, diff;
  logic [2:0] k;
  logic [3:0] rg_lo, rg_hi;
  logic       pend_v;
  logic [3:0] pend_rg;
  logic [1:0] pend_at;

  assign wr_go   = acc_we && (acc_fn == '0) && !locked(acc_off) && !master_rst;
  assign w_en    = wr_go || master_rst;
  assign w_off   = master_rst ? ATTR_BASE : acc_off;
  assign w_val   = master_rst ? 8'h00 : filt(acc_off, acc_wdata);
  assign diff    = cfg[w_off] ^ w_val;
  assign in_attr = (w_off >= ATTR_BASE) && (w_off <= ATTR_LAST);
  assign k       = 3'(w_off - ATTR_BASE);
  assign mute    = strap_mute5b && (w_off == MUTE_OFF);
  assign ev_lo   = w_en && in_attr && (k != 3'd0) && !mute && (diff[3:0] != 4'h0);
  assign ev_hi   = w_en && in_attr && !mute && (diff[7:4] != 4'h0);
  assign rg_lo   = {k, 1'b0} - 4'd1;
  assign rg_hi   = {k, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg[i] <= dflt(8'(i), variant_sel);
    end else if (w_en) begin
      cfg[w_off] <= w_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid  <= 1'b0;
      upd_region <= '0;
      upd_attr   <= '0;
      pend_v     <= 1'b0;
      pend_rg    <= '0;
      pend_at    <= '0;
    end else if (ev_lo) begin
      upd_valid  <= 1'b1;
      upd_region <= rg_lo;
      upd_attr   <= w_val[1:0];
      pend_v     <= ev_hi;
      pend_rg    <= rg_hi;
      pend_at    <= w_val[5:4];
    end else if (ev_hi) begin
      upd_valid  <= 1'b1;
      upd_region <= rg_hi;
      upd_attr   <= w_val[5:4];
      pend_v     <= 1'b0;
    end else begin
      upd_valid  <= pend_v;
      upd_region <= pend_rg;
      upd_attr   <= pend_at;
      pend_v     <= 1'b0;
    end
  end

  assign acc_rdata = (acc_fn != '0) ? 8'hFF : cfg[acc_off];
  assign shadow_on = cfg[ATTR_BASE][4];

  for (genvar g = 0; g < N_ATTR; g++) begin : g_attr
    assign attr_bytes[8*g +: 8] = cfg[ATTR_BASE + 8'(g)];
  end
endmodule

// File: rtl/hb_cfg_space_chk.sv
module hb_cfg_space_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strap_mute5b,
  input logic        master_rst,
  input logic [2:0]  acc_fn,
  input logic [7:0]  acc_off,
  input logic        acc_we,
  input logic [7:0]  acc_wdata,
  input logic [7:0]  acc_rdata,
  input logic [55:0] attr_bytes,
  input logic        shadow_on,
  input logic        upd_valid,
  input logic [3:0]  upd_region,
  input logic [1:0]  upd_attr
);
  AST_FOREIGN_FN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_fn != 3'd0 && !master_rst) |=> $stable(attr_bytes)); // R1

  AST_CMD_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_we && acc_fn == 3'd0 && acc_off == 8'h04 && !master_rst) &&
     acc_fn == 3'd0 && acc_off == 8'h04) |-> (acc_rdata[2] && (acc_rdata & 8'hB9) == 8'h00)); // R3

  AST_SHADOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadow_on) |-> $past(acc_we && acc_fn == 3'd0 && acc_off == 8'h59 && acc_wdata[4] && !master_rst)); // R7

  AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_region <= 4'd12)); // R8

  AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !$past(upd_valid)) |-> $past(master_rst || (acc_we && acc_fn == 3'd0))); // R10

  AST_MRST_BIOS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_rst && attr_bytes[7:4] != 4'h0) |=> (upd_valid && upd_region == 4'd0 && upd_attr == 2'd0)); // R9

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_fn == 3'd0 && acc_off == 8'h5A && !master_rst &&
     ((acc_wdata ^ attr_bytes[15:8]) & 8'h0F) != 8'h00 &&
     ((acc_wdata ^ attr_bytes[15:8]) & 8'hF0) != 8'h00)
    |=> (upd_valid && upd_region == 4'd1) ##1 (upd_valid && upd_region == 4'd2)); // R10

  AST_STRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_mute5b && acc_we && acc_fn == 3'd0 && acc_off == 8'h5B && !master_rst)
    |=> !(upd_valid && (upd_region == 4'd3 || upd_region == 4'd4))); // R11
endmodule

bind hb_cfg_space hb_cfg_space_chk i_chk (
  .clk(clk), .rst_n(rst_n), .strap_mute5b(strap_mute5b), .master_rst(master_rst),
  .acc_fn(acc_fn), .acc_off(acc_off), .acc_we(acc_we), .acc_wdata(acc_wdata),
  .acc_rdata(acc_rdata), .attr_bytes(attr_bytes), .shadow_on(shadow_on),
  .upd_valid(upd_valid), .upd_region(upd_region), .upd_attr(upd_attr)
);

// File: tb/test_hb_cfg_space.sv
module test_hb_cfg_space;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, variant_sel = 1'b0, strap_mute5b = 1'b0, master_rst = 1'b0;
  logic [2:0] acc_fn = '0;
  logic [7:0] acc_off = '0, acc_wdata = '0;
  logic acc_we = 1'b0;
  logic [7:0] acc_rdata;
  logic [55:0] attr_bytes;
  logic shadow_on, upd_valid;
  logic [3:0] upd_region;
  logic [1:0] upd_attr;

  int total = 0, bad = 0;
  logic [7:0] mdl [256];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_cfg_space i_hb_cfg_space (.*);

  function automatic logic [7:0] exp_dflt(input int o, input logic v);
    if (o == 8'h08) return v ? 8'h10 : 8'h03;
    if (o == 8'h50) return v ? 8'hA0 : 8'h80;
    if (o == 8'h52) return v ? 8'h44 : 8'h40;
    if (o == 8'h66 || o == 8'h67) return v ? 8'h02 : 8'h00;
    if (o >= 8'h60 && o <= 8'h64) return 8'h02;
    case (o)
      0: return 8'h86; 1: return 8'h80; 2: return 8'hA3; 3: return 8'h04;
      4: return 8'h06; 7: return 8'h02; 8'h0B: return 8'h06; 8'h57: return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_ro(input int o);
    return (o >= 16 && o <= 8'h4E) || o <= 3 || (o >= 8 && o <= 12) || o == 14;
  endfunction

  function automatic string tag_of(input int o);
    if (is_ro(o)) return "R2";
    if (o == 4 || o == 5) return "R3";
    if (o == 6 || o == 7) return "R4";
    if (o >= 8'h59 && o <= 8'h5F) return "R12";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic v);
    @(negedge clk);
    rst_n = 1'b0; variant_sel = v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) mdl[i] = exp_dflt(i, v);
  endtask

  task automatic rd_chk(input logic [2:0] fn, input int o, input logic [7:0] e, input string req);
    @(negedge clk);
    acc_fn = fn; acc_off = 8'(o);
    #1 chk(acc_rdata == e, req, acc_rdata, e);
    acc_fn = 3'd0;
  endtask

  task automatic slot_chk(input bit ev, input int rg, input int at, input string req);
    if (ev) chk(upd_valid && upd_region == 4'(rg) && upd_attr == 2'(at), req,
                {upd_valid, upd_region, upd_attr}, {1'b1, 4'(rg), 2'(at)});
    else chk(!upd_valid, req, upd_valid, 0);
  endtask

  task automatic wr(input logic [2:0] fn, input int o, input logic [7:0] d, input bit mr);
    bit ev0 = 0, ev1 = 0;
    int r0 = 0, r1 = 0, a0 = 0, a1 = 0;
    int eo;
    logic [7:0] nv, old;
    string ntag;
    bit live;
    eo = mr ? 8'h59 : o;
    live = mr || (fn == 0 && !is_ro(o));
    if (mr) nv = 8'h00;
    else if (o == 4) nv = (d & 8'h42) | 8'h04;
    else if (o == 5) nv = d & 8'h01;
    else if (o == 6) nv = 8'h00;
    else if (o == 7) nv = 8'h02;
    else nv = d;
    old = mdl[eo];
    ntag = mr ? "R9" : (eo == 8'h59 ? "R7" : ((eo == 8'h5B && strap_mute5b) ? "R11" : (fn != 0 ? "R1" : "R8")));
    if (live && eo >= 8'h59 && eo <= 8'h5F && !(eo == 8'h5B && strap_mute5b)) begin
      int kk = eo - 8'h59;
      if (kk != 0 && old[3:0] != nv[3:0]) begin ev0 = 1; r0 = 2*kk - 1; a0 = nv[1:0]; end
      if (old[7:4] != nv[7:4]) begin
        if (ev0) begin ev1 = 1; r1 = 2*kk; a1 = nv[5:4]; end
        else begin ev0 = 1; r0 = (kk == 0) ? 0 : 2*kk; a0 = nv[5:4]; end
      end
    end
    if (live) mdl[eo] = nv;
    @(negedge clk);
    acc_fn = fn; acc_off = 8'(o); acc_wdata = d; acc_we = 1'b1; master_rst = mr;
    @(negedge clk);
    acc_we = 1'b0; master_rst = 1'b0; acc_fn = 3'd0;
    #1 slot_chk(ev0, r0, a0, ntag);
    @(negedge clk);
    #1 slot_chk(ev1, r1, a1, ev1 ? "R10" : ntag);
    if (eo == 8'h59) chk(shadow_on == mdl[8'h59][4], mr ? "R9" : "R7", shadow_on, mdl[8'h59][4]);
  endtask

  task automatic attr_chk;
    for (int kk = 0; kk < 7; kk++)
      chk(attr_bytes[8*kk +: 8] == mdl[8'h59 + kk], "R12", attr_bytes[8*kk +: 8], mdl[8'h59 + kk]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 2; v++) begin
      do_reset(1'(v));
      // R5 R6: reset image, R1 foreign functions read 0xFF
      for (int o = 0; o < 256; o++) begin
        string t = (o == 8 || o == 8'h50 || o == 8'h52 || o == 8'h66 || o == 8'h67) ? "R6" : "R5";
        rd_chk(3'd0, o, mdl[o], t);
      end
      for (int f = 1; f < 8; f++) rd_chk(3'(f), 8'h00, 8'hFF, "R1");
      chk(!upd_valid && !shadow_on, "R5", {upd_valid, shadow_on}, 0);
      attr_chk();
      // write sweep over every offset with two patterns
      for (int o = 0; o < 256; o++) begin
        wr(3'd0, o, 8'hFF, 1'b0); rd_chk(3'd0, o, mdl[o], tag_of(o));
        wr(3'd0, o, 8'h00, 1'b0); rd_chk(3'd0, o, mdl[o], tag_of(o));
      end
    end
    // R3 R4: all data values into command/status bytes
    for (int o = 4; o < 8; o++)
      for (int d = 0; d < 256; d++) begin
        wr(3'd0, o, 8'(d), 1'b0); rd_chk(3'd0, o, mdl[o], tag_of(o));
      end
    // R1: foreign-function writes ignored
    for (int f = 1; f < 8; f++) begin
      wr(3'(f), 8'h5A, 8'h33, 1'b0); rd_chk(3'd0, 8'h5A, mdl[8'h5A], "R1");
      wr(3'(f), 8'h60, 8'h77, 1'b0); rd_chk(3'd0, 8'h60, mdl[8'h60], "R1");
    end
    // R7 R8 R10 R12: every value into every attribute byte
    for (int kk = 0; kk < 7; kk++)
      for (int d = 0; d < 256; d++) wr(3'd0, 8'h59 + kk, 8'(d ^ (d << 4)), 1'b0);
    attr_chk();
    // R11: strap mutes 0x5B notifications but stores
    strap_mute5b = 1'b1;
    for (int d = 0; d < 16; d++) begin
      wr(3'd0, 8'h5B, 8'(d * 8'h11 + 1), 1'b0); rd_chk(3'd0, 8'h5B, mdl[8'h5B], "R11");
    end
    wr(3'd0, 8'h5C, 8'h21, 1'b0);
    strap_mute5b = 1'b0;
    wr(3'd0, 8'h5B, 8'h00, 1'b0);
    // R9: master reset, alone and racing an access write
    wr(3'd0, 8'h59, 8'h3A, 1'b0);
    wr(3'd0, 8'h00, 8'h00, 1'b1);
    rd_chk(3'd0, 8'h59, 8'h00, "R9");
    wr(3'd0, 8'h00, 8'h00, 1'b1);
    wr(3'd0, 8'h59, 8'h13, 1'b0);
    wr(3'd0, 8'h04, 8'hFF, 1'b1);
    rd_chk(3'd0, 8'h04, mdl[8'h04], "R9");
    rd_chk(3'd0, 8'h59, 8'h00, "R9");
    attr_chk();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule